// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a two-wire serial slave that answers a single 7-bit device address and holds thirteen 8-bit control registers for the surrounding chip. The bus lines are oversampled by the fast system clock, so the block sees SCL and SDA only through a synchronizer. Start and stop conditions and SCL edges are recovered in the system clock domain.

Transfers carry no register offset. A write is the address byte, then two filler bytes that are acknowledged and thrown away, then a stream of data bytes. The data bytes fill register 0, then register 1, and so on. A read returns register 0, then register 1, and so on, until the master refuses a byte. The index stops advancing at the last register.

The register contents are presented in parallel on one flat output. Two identification registers are fixed. The five high bits of register 4 report strap inputs that are captured while reset is held. Writes to fixed bits are acknowledged but change nothing.

Top module: `serreg_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal `DEV_ADDR` (default 0x69). Any other address is not acknowledged, and SDA is then left released until the next START.
- R2: In a write transfer (address bit 0 = 0), the first two bytes after the address are acknowledged and change no register.
- R3: Each data byte after those two is acknowledged and stored into the next register in order, starting at register 0. A register changes only when a complete data byte is written to it.
- R4: In a read transfer (address bit 0 = 1), each byte is driven MSB first. The bytes are register 0, then 1, then 2, and so on, with no filler byte.
- R5: Register 11 always reads 0x05 and register 12 always reads 0x31. Bit 6 of register 6 always reads 0. Writes to these bits are acknowledged and have no effect.
- R6: Register 4 bits [7:3] hold `strap_i` as sampled during reset, and writes do not change them. Bits [2:0] are writable and reset to 3'b111.
- R7: After reset, the registers hold these values. Registers 0, 6, 8, 9 and 10 hold 0x00. Register 1 holds 0xCF. Registers 2 and 3 hold 0xFF. Register 5 holds 0x93 and register 7 holds 0x40.
- R8: A STOP or a repeated START at any bit position abandons the byte in progress without writing it. After a STOP the slave goes idle; after a START it waits for a new address byte.
- R9: When the master answers a read byte with NACK, the slave releases SDA and drives nothing until the next START.
- R10: After register 12, the index holds at 12. Further reads return 0x31, and further writes are acknowledged and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset; `strap_i` is captured while it is high |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 5 | Strap levels reported in register 4 bits [7:3] |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | 104 | All registers in parallel; register n occupies bits [8n+7:8n] |

## Verification
A bit counter or kind tracker that falls out of step shows up directly at the ports. The acknowledge slot is either missing or moved, and data lands in the register one index away. Both can be seen on `regs_o` or on the bus within one byte time. A corrupted write mask shows up as a changed fixed bit on `regs_o` in the cycle after the byte completes. A stuck drive enable holds SDA low through the next bit slot, and the master's next sampled bit reads as zero. Random write lengths and readback lengths reach both ends of the register index within a few transfers.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

    localparam int REG_COUNT = 13;
    localparam int IDX_W     = $clog2(REG_COUNT);
    localparam int FLAT_W    = REG_COUNT * 8;
    localparam int STRAP_W   = 5;
    localparam int STRAP_REG = 4;

    typedef logic [7:0]       byte_t;
    typedef logic [IDX_W-1:0] idx_t;

    // Byte-level protocol phase.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    // Meaning of the next received byte.
    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_CNT,
        K_DATA
    } kind_e;

    // Recovered bus events in the system clock domain.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic byte_t reg_default(input int i);
        case (i)
            1:       return 8'hCF;
            2, 3:    return 8'hFF;
            4:       return 8'h07;
            5:       return 8'h93;
            7:       return 8'h40;
            11:      return 8'h05;
            12:      return 8'h31;
            default: return 8'h00;
        endcase
    endfunction

    // A set bit can be written by the bus.
    function automatic byte_t reg_wmask(input int i);
        case (i)
            4:       return 8'h07;
            6:       return 8'hBF;
            11, 12:  return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic idx_t idx_next(input idx_t i);
        return (i == idx_t'(REG_COUNT - 1)) ? i : i + idx_t'(1);
    endfunction

endpackage

// File: rtl/serreg_sync.sv
module serreg_sync
    import serreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
    import serreg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wr_en,
    input  idx_t               wr_idx,
    input  byte_t              wr_data,
    input  idx_t               rd_idx,
    output byte_t              rd_data,
    output logic [FLAT_W-1:0]  regs_o
);

    byte_t arr [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        localparam byte_t MASK = reg_wmask(g);
        localparam byte_t DFLT = reg_default(g);
        byte_t q;

        always_ff @(posedge clk) begin
            if (rst) begin
                if (g == STRAP_REG) q <= {strap_i, DFLT[2:0]};
                else                q <= DFLT;
            end else if (wr_en && wr_idx == idx_t'(g)) begin
                q <= (q & ~MASK) | (wr_data & MASK);
            end
        end

        assign arr[g]           = q;
        assign regs_o[g*8 +: 8] = q;
    end

    always_comb rd_data = arr[rd_idx];

endmodule

// File: rtl/serreg_link.sv
module serreg_link
    import serreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  byte_t   rd_data,
    output logic    sda_oe,
    output logic    wr_en,
    output idx_t    wr_idx,
    output byte_t   wr_data,
    output idx_t    idx,
    output phase_e  phase
);

    kind_e      kind;
    logic [3:0] bitcnt;
    byte_t      shreg;
    logic       rw;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            kind    <= K_ADDR;
            bitcnt  <= '0;
            shreg   <= '0;
            rw      <= 1'b0;
            idx     <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                phase  <= PH_RX;
                kind   <= K_ADDR;
                bitcnt <= '0;
                idx    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (ev.rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (kind == K_ADDR && shreg[7:1] != DEV_ADDR) begin
                                phase <= PH_IDLE;
                            end else begin
                                phase  <= PH_RX_ACK;
                                sda_oe <= 1'b1;
                                if (kind == K_ADDR) rw <= shreg[0];
                                if (kind == K_DATA) begin
                                    wr_en   <= 1'b1;
                                    wr_data <= shreg;
                                    wr_idx  <= idx;
                                    idx     <= idx_next(idx);
                                end
                            end
                        end
                    end
                    PH_RX_ACK: begin
                        if (ev.fall) begin
                            if (kind == K_ADDR && rw) begin
                                phase  <= PH_TX;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                phase  <= PH_RX;
                                sda_oe <= 1'b0;
                                if (kind != K_DATA) kind <= kind_e'(kind + 2'd1);
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.fall) begin
                            if (bitcnt == 4'd7) begin
                                phase  <= PH_TX_ACK;
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                            end else begin
                                bitcnt <= bitcnt + 4'd1;
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (ev.rise) begin
                            if (ev.sda) phase <= PH_IDLE;
                            else        idx   <= idx_next(idx);
                        end else if (ev.fall) begin
                            phase  <= PH_TX;
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
    import serreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe,
    output logic [FLAT_W-1:0]  regs_o
);

    bus_ev_t ev;
    byte_t   rd_data;
    byte_t   wr_data;
    idx_t    wr_idx;
    idx_t    cur_idx;
    logic    wr_en;
    phase_e  phase;

    serreg_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    serreg_link #(.DEV_ADDR(DEV_ADDR)) link_i (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (rd_data),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .idx     (cur_idx),
        .phase   (phase)
    );

    serreg_bank bank_i (
        .clk     (clk),
        .rst     (rst),
        .strap_i (strap_i),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (cur_idx),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

endmodule

// File: rtl/serreg_chk.sv
module serreg_chk
    import serreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input phase_e            phase,
    input logic              wr_en,
    input logic [FLAT_W-1:0] regs
);

    p_stop_release_r8: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    p_start_release_r8: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);

    p_drive_active_r9: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> phase != PH_IDLE);

    p_quiet_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));

    p_ident_r5: assert property (@(posedge clk) disable iff (rst)
        regs[11*8 +: 8] == 8'h05 && regs[12*8 +: 8] == 8'h31);

    p_strap_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(regs[STRAP_REG*8+3 +: STRAP_W]));

endmodule

bind serreg_slave serreg_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start_det (ev.start),
    .stop_det  (ev.stop),
    .sda_oe    (sda_oe),
    .phase     (phase),
    .wr_en     (wr_en),
    .regs      (regs_o)
);

// File: tb/serreg_slave_tb_top.sv
module serreg_slave_tb_top;

    localparam int         Q    = 6;
    localparam logic [6:0] ADDR = 7'h69;
    localparam int         NREG = 13;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic [4:0]   strap = 5'b10110;
    logic         sda_oe;
    logic [103:0] regs_o;
    logic         sda_bus;

    int nerr = 0;
    int nchk = 0;
    logic [7:0] expm [NREG];

    assign sda_bus = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    serreg_slave dut_i (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_m),
        .sda_i   (sda_bus),
        .strap_i (strap),
        .sda_oe  (sda_oe),
        .regs_o  (regs_o)
    );

    function automatic logic [7:0] m_default(input int i, input logic [4:0] s);
        case (i)
            1:       return 8'hCF;
            2, 3:    return 8'hFF;
            4:       return {s, 3'b111};
            5:       return 8'h93;
            7:       return 8'h40;
            11:      return 8'h05;
            12:      return 8'h31;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_mask(input int i);
        if (i == 4)            return 8'h07;
        if (i == 6)            return 8'hBF;
        if (i == 11 || i == 12) return 8'h00;
        return 8'hFF;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b0; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b1; hq();
    endtask

    task automatic wbit(input logic b);
        sda_m = b; hq();
        scl_m = 1'b1; hq(); hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        b = sda_bus; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(~ack);
    endtask

    task automatic cmp_regs(input string tag);
        for (int i = 0; i < NREG; i++) chk(regs_o[i*8 +: 8], expm[i], tag);
    endtask

    task automatic m_write(input logic [7:0] d, inout int ix);
        expm[ix] = (expm[ix] & ~m_mask(ix)) | (d & m_mask(ix));
        if (ix < NREG - 1) ix++;
    endtask

    // Write transfer: address, two filler bytes, n data bytes from a base pattern.
    task automatic do_write(input int n, input logic [7:0] seed, input logic rnd);
        logic ack;
        logic [7:0] d;
        int ix = 0;
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        chk({7'd0, ack}, 8'd1, "R1 address ack");
        send_byte(8'($urandom), ack);
        chk({7'd0, ack}, 8'd1, "R2 filler ack");
        send_byte(8'($urandom), ack);
        chk({7'd0, ack}, 8'd1, "R2 filler ack");
        for (int k = 0; k < n; k++) begin
            d = rnd ? 8'($urandom) : seed + 8'(k * 17);
            send_byte(d, ack);
            chk({7'd0, ack}, 8'd1, "R3 data ack");
            m_write(d, ix);
        end
        bus_stop();
        hq();
        cmp_regs("R3 stored");
    endtask

    // Read transfer: n bytes, last one refused.
    task automatic do_read(input int n);
        logic ack;
        logic [7:0] d;
        int ix = 0;
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        chk({7'd0, ack}, 8'd1, "R1 read address ack");
        for (int k = 0; k < n; k++) begin
            recv_byte(d, k != n - 1);
            chk(d, expm[ix], (k >= NREG) ? "R10 held index read" : "R4 read order");
            if (ix < NREG - 1) ix++;
        end
        hq();
        chk({7'd0, sda_oe}, 8'd0, "R9 released after nack");
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic b;
        logic [7:0] d;
        void'($urandom(32'h5eed));
        for (int i = 0; i < NREG; i++) expm[i] = m_default(i, strap);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        strap = 5'b01001;
        repeat (4) @(negedge clk);

        cmp_regs("R7 reset value");
        chk(regs_o[4*8 +: 8], 8'hB7, "R6 strap capture");
        chk({7'd0, sda_oe}, 8'd0, "R7 idle release");

        do_write(3, 8'hA5, 1'b0);
        do_read(15);

        // Zeros into every register and past the end.
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        for (int k = 0; k < 15; k++) begin
            send_byte(8'h00, ack);
            chk({7'd0, ack}, 8'd1, "R10 ack beyond end");
        end
        bus_stop();
        hq();
        chk(regs_o[6*8 +: 8], 8'h00, "R5 reg6 cleared");
        chk(regs_o[4*8 +: 8], 8'hB0, "R6 strap bits kept");
        chk(regs_o[11*8 +: 8], 8'h05, "R5 id low");
        chk(regs_o[12*8 +: 8], 8'h31, "R5 id high");
        for (int i = 0; i < NREG; i++) expm[i] = expm[i] & ~m_mask(i);

        // All ones: fixed bits must not move.
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'hFF, ack);
        send_byte(8'hFF, ack);
        for (int k = 0; k < NREG; k++) send_byte(8'hFF, ack);
        bus_stop();
        hq();
        for (int i = 0; i < NREG; i++) expm[i] = expm[i] | m_mask(i);
        chk(regs_o[6*8 +: 8], 8'hBF, "R5 reg6 bit6 fixed");
        chk(regs_o[4*8 +: 8], 8'hB7, "R6 strap bits kept");
        cmp_regs("R5 masked write");

        // Wrong address: no ack and nothing stored.
        bus_start();
        send_byte({ADDR ^ 7'h01, 1'b0}, ack);
        chk({7'd0, ack}, 8'd0, "R1 foreign address nack");
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        send_byte(8'h12, ack);
        chk({7'd0, ack}, 8'd0, "R1 stays silent");
        bus_stop();
        hq();
        cmp_regs("R1 foreign write ignored");

        // STOP inside a data byte.
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        for (int k = 0; k < 4; k++) wbit(1'b0);
        bus_stop();
        hq();
        cmp_regs("R8 stop abort");

        // Repeated START inside the filler byte, then a read.
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        wbit(1'b0); wbit(1'b1); wbit(1'b0);
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        chk({7'd0, ack}, 8'd1, "R8 restart address ack");
        recv_byte(d, 1'b0);
        chk(d, expm[0], "R8 restart read reg0");
        hq();
        rbit(b);
        chk({7'd0, b}, 8'd1, "R9 bus free after nack");
        bus_stop();
        hq();
        cmp_regs("R8 restart abort");

        for (int it = 0; it < 6; it++) begin
            do_write(1 + int'($urandom % 14), 8'h00, 1'b1);
            do_read(1 + int'($urandom % 13));
        end

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule